// File: doc/BRIEF.md
# Parallel Pixel Output Formatter

The formatter sits between a pixel pipeline and a parallel display port. Each clock it may accept one pixel of three 12-bit components (R/G/B, or Y/Cb/Cr in the same lane order) with a valid flag and a start-of-line marker. It produces a three-lane output word, each lane 16 bits wide. Along the way it can exchange the first and third inputs, clamp luma and chroma into their own windows, reorder or pack the components, and narrow or widen each one to the chosen depth.

All settings come from a configuration input that is copied into a working set only while `soft_rst_i` is high. Software holds the block in soft reset, presents the settings, and then releases it. Two enable flags, one for 4:2:2 and one for colour conversion, are carried through the working set to outputs for downstream stages. The block does no arithmetic on them.

Top module: `pix_out_fmt`

## Requirements
- R1: After `rst_ni` the working set is: no swap, order 0, mode 0, depth 0, both flags 0, luma and chroma limits bottom 0x010 and top 0xFE0.
- R2: A pixel sampled with `pix_valid_i` high appears on `out_data_o` with `out_valid_o` high exactly two clocks later. While `out_valid_o` is low, `out_data_o` is zero.
- R3: When the swap bit is set, input components 0 and 2 are exchanged before clamping, ordering and packing.
- R4: In mode 0 the order code maps output lanes 0/1/2 (lane k at bits 16k+15:16k) as follows. 0=R,G,B; 1=G,B,R; 2=B,R,G; 3=R,B,G; 4=G,R,B; 5=B,G,R. Codes 6 and 7 behave as 0.
- R5: In modes 1 to 4, component 0 is clamped to [y_lo, y_hi] and components 1 and 2 to [c_lo, c_hi]. Mode 0 applies no clamp.
- R6: Mode 2 (Y-C-Y-C) outputs lane0=Y and lane1=Cb on even pixels, Cr on odd. Mode 1 (C-Y-C-Y) outputs lane0=Cb/Cr alternating and lane1=Y. In both modes lane 2 is zero.
- R7: The even/odd pixel count restarts at even on every valid pixel with `pix_sol_i` high.
- R8: Mode 3 (C-Y) outputs lanes Cb,Y,Cr and mode 4 (Y-C) outputs Y,Cb,Cr, with the order code ignored. Mode codes 5 to 7 behave as mode 0.
- R9: Depth code 0 gives 8 bits (value[11:4]), 1 gives 10 bits (value[11:2]), 2 gives 12 bits, and 3 gives 16 bits (value shifted left by 4). The result sits in the low bits of the lane and the unused upper bits are zero. Codes 4 to 7 behave as 0.
- R10: The configuration inputs change nothing while `soft_rst_i` is low. While it is high, the working set follows them, pixels are dropped, and `out_valid_o` is low from the next clock on.
- R11: `out_422_en_o` and `out_csc_en_o` show the two enable flags held in the working set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| soft_rst_i | input | 1 | soft reset; loads the working configuration |
| cfg_rb_swap_i | input | 1 | exchange input components 0 and 2 |
| cfg_order_i | input | 3 | output order code (mode 0) |
| cfg_ycmode_i | input | 3 | luma/chroma packing mode |
| cfg_depth_i | input | 3 | output depth code |
| cfg_422_en_i | input | 1 | 4:2:2 enable flag |
| cfg_csc_en_i | input | 1 | colour conversion enable flag |
| cfg_y_lo_i | input | 12 | luma bottom limit |
| cfg_y_hi_i | input | 12 | luma top limit |
| cfg_c_lo_i | input | 12 | chroma bottom limit |
| cfg_c_hi_i | input | 12 | chroma top limit |
| pix_valid_i | input | 1 | pixel valid |
| pix_sol_i | input | 1 | first active pixel of a line |
| pix_c0_i | input | 12 | component 0 (R or Y) |
| pix_c1_i | input | 12 | component 1 (G or Cb) |
| pix_c2_i | input | 12 | component 2 (B or Cr) |
| out_valid_o | output | 1 | output word valid |
| out_data_o | output | 48 | three 16-bit output lanes |
| out_422_en_o | output | 1 | working 4:2:2 flag |
| out_csc_en_o | output | 1 | working conversion flag |

## Verification
The assertions check several rules on every cycle. Each output is backed by a valid input two clocks earlier. Data is zero when no word is valid. Soft reset silences the output. The flags hold steady outside soft reset. The 8-bit depth leaves each lane's upper byte zero, and the two alternating modes leave lane 2 empty. The exact lane contents can only be shown by the bench's scenarios. Those cover every order code, the swap, the clamp windows with default and custom limits, each packing mode, the phase restart at line start, each depth with its fallback, and configuration writes made outside soft reset being ignored.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam logic [2:0] YCM_RGB  = 3'd0;
  localparam logic [2:0] YCM_CYCY = 3'd1;
  localparam logic [2:0] YCM_YCYC = 3'd2;
  localparam logic [2:0] YCM_CY   = 3'd3;
  localparam logic [2:0] YCM_YC   = 3'd4;

  localparam logic [2:0] DEP_8  = 3'd0;
  localparam logic [2:0] DEP_10 = 3'd1;
  localparam logic [2:0] DEP_12 = 3'd2;
  localparam logic [2:0] DEP_16 = 3'd3;

  localparam logic [1:0] SRC_ZERO = 2'd3;

  typedef struct packed {
    logic       swap;
    logic [2:0] ord;
    logic [2:0] ycm;
    logic [2:0] dep;
    logic       f422;
    logic       fcsc;
  } mode_t;

  // source component per output lane for the six orders, {lane2,lane1,lane0}
  function automatic logic [1:0] perm_src(logic [2:0] ord, int lane);
    logic [5:0] m;
    case (ord)
      3'd1:    m = 6'b00_10_01;
      3'd2:    m = 6'b01_00_10;
      3'd3:    m = 6'b01_10_00;
      3'd4:    m = 6'b10_00_01;
      3'd5:    m = 6'b00_01_10;
      default: m = 6'b10_01_00;
    endcase
    return m[2*lane +: 2];
  endfunction

  function automatic logic [1:0] lane_src(logic [2:0] ycm, logic [2:0] ord,
                                          logic odd, int lane);
    case (ycm)
      YCM_CYCY: return (lane == 0) ? (odd ? 2'd2 : 2'd1) : (lane == 1) ? 2'd0 : SRC_ZERO;
      YCM_YCYC: return (lane == 0) ? 2'd0 : (lane == 1) ? (odd ? 2'd2 : 2'd1) : SRC_ZERO;
      YCM_CY:   return (lane == 0) ? 2'd1 : (lane == 1) ? 2'd0 : 2'd2;
      YCM_YC:   return 2'(lane);
      default:  return perm_src(ord, lane);
    endcase
  endfunction
endpackage

// File: rtl/pof_cfg.sv
module pof_cfg
  import pof_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  mode_t         mode_i,
  input  logic [CW-1:0] y_lo_i,
  input  logic [CW-1:0] y_hi_i,
  input  logic [CW-1:0] c_lo_i,
  input  logic [CW-1:0] c_hi_i,
  output mode_t         mode_o,
  output logic [CW-1:0] y_lo_o,
  output logic [CW-1:0] y_hi_o,
  output logic [CW-1:0] c_lo_o,
  output logic [CW-1:0] c_hi_o
);
  localparam logic [CW-1:0] LO_DEF = CW'(1) << (CW-8);
  localparam logic [CW-1:0] HI_DEF = '1 - ((CW'(1) << (CW-7)) - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      y_lo_o <= LO_DEF;
      y_hi_o <= HI_DEF;
      c_lo_o <= LO_DEF;
      c_hi_o <= HI_DEF;
    end else if (soft_rst_i) begin
      mode_o <= mode_i;
      y_lo_o <= y_lo_i;
      y_hi_o <= y_hi_i;
      c_lo_o <= c_lo_i;
      c_hi_o <= c_hi_i;
    end
  end
endmodule

// File: rtl/pof_front.sv
module pof_front
  import pof_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                swap_i,
  input  logic [2:0]          ycm_i,
  input  logic [CW-1:0]       y_lo_i,
  input  logic [CW-1:0]       y_hi_i,
  input  logic [CW-1:0]       c_lo_i,
  input  logic [CW-1:0]       c_hi_i,
  input  logic                valid_i,
  input  logic                sol_i,
  input  logic [2:0][CW-1:0]  comp_i,
  output logic                valid_o,
  output logic                odd_o,
  output logic [2:0][CW-1:0]  comp_o
);
  logic [2:0][CW-1:0] raw, clamped;
  logic clamp_en, odd_q, cur_odd;

  assign raw[0]   = swap_i ? comp_i[2] : comp_i[0];
  assign raw[1]   = comp_i[1];
  assign raw[2]   = swap_i ? comp_i[0] : comp_i[2];
  assign clamp_en = (ycm_i >= YCM_CYCY) && (ycm_i <= YCM_YC);
  assign cur_odd  = sol_i ? 1'b0 : odd_q;

  for (genvar g = 0; g < 3; g++) begin : g_clamp
    logic [CW-1:0] lo, hi;
    assign lo = (g == 0) ? y_lo_i : c_lo_i;
    assign hi = (g == 0) ? y_hi_i : c_hi_i;
    always_comb begin
      if (!clamp_en)        clamped[g] = raw[g];
      else if (raw[g] < lo) clamped[g] = lo;
      else if (raw[g] > hi) clamped[g] = hi;
      else                  clamped[g] = raw[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      odd_o   <= 1'b0;
      odd_q   <= 1'b0;
      comp_o  <= '0;
    end else if (soft_rst_i) begin
      valid_o <= 1'b0;
      odd_o   <= 1'b0;
      odd_q   <= 1'b0;
      comp_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        comp_o <= clamped;
        odd_o  <= cur_odd;
        odd_q  <= ~cur_odd;
      end
    end
  end
endmodule

// File: rtl/pof_back.sv
module pof_back
  import pof_pkg::*;
#(
  parameter int CW = 12,
  parameter int LW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [2:0]          ycm_i,
  input  logic [2:0]          ord_i,
  input  logic [2:0]          dep_i,
  input  logic                valid_i,
  input  logic                odd_i,
  input  logic [2:0][CW-1:0]  comp_i,
  output logic                valid_o,
  output logic [3*LW-1:0]     data_o
);
  function automatic logic [LW-1:0] scale(logic [CW-1:0] v, logic [2:0] d);
    logic [LW-1:0] z;
    z = LW'(v);
    case (d)
      DEP_10:  return z >> (CW-10);
      DEP_12:  return z;
      DEP_16:  return z << (LW-CW);
      default: return z >> (CW-8);
    endcase
  endfunction

  logic [3*LW-1:0] data_c;

  for (genvar g = 0; g < 3; g++) begin : g_lane
    logic [1:0]    src;
    logic [CW-1:0] sel;
    assign src = lane_src(ycm_i, ord_i, odd_i, g);
    assign sel = (src == SRC_ZERO) ? '0 : comp_i[src];
    assign data_c[g*LW +: LW] = scale(sel, dep_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (soft_rst_i) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      data_o  <= valid_i ? data_c : '0;
    end
  end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
#(
  parameter int CW = 12,
  parameter int LW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_i,
  input  logic            cfg_rb_swap_i,
  input  logic [2:0]      cfg_order_i,
  input  logic [2:0]      cfg_ycmode_i,
  input  logic [2:0]      cfg_depth_i,
  input  logic            cfg_422_en_i,
  input  logic            cfg_csc_en_i,
  input  logic [CW-1:0]   cfg_y_lo_i,
  input  logic [CW-1:0]   cfg_y_hi_i,
  input  logic [CW-1:0]   cfg_c_lo_i,
  input  logic [CW-1:0]   cfg_c_hi_i,
  input  logic            pix_valid_i,
  input  logic            pix_sol_i,
  input  logic [CW-1:0]   pix_c0_i,
  input  logic [CW-1:0]   pix_c1_i,
  input  logic [CW-1:0]   pix_c2_i,
  output logic            out_valid_o,
  output logic [3*LW-1:0] out_data_o,
  output logic            out_422_en_o,
  output logic            out_csc_en_o
);
  mode_t              cfg_in, wmode;
  logic [CW-1:0]      y_lo, y_hi, c_lo, c_hi;
  logic               s1_valid, s1_odd;
  logic [2:0][CW-1:0] s1_comp;

  assign cfg_in = '{swap: cfg_rb_swap_i, ord: cfg_order_i, ycm: cfg_ycmode_i,
                    dep: cfg_depth_i, f422: cfg_422_en_i, fcsc: cfg_csc_en_i};

  pof_cfg #(.CW(CW)) i_cfg (
    .clk_i, .rst_ni, .soft_rst_i,
    .mode_i (cfg_in),
    .y_lo_i (cfg_y_lo_i), .y_hi_i (cfg_y_hi_i),
    .c_lo_i (cfg_c_lo_i), .c_hi_i (cfg_c_hi_i),
    .mode_o (wmode),
    .y_lo_o (y_lo), .y_hi_o (y_hi), .c_lo_o (c_lo), .c_hi_o (c_hi)
  );

  pof_front #(.CW(CW)) i_front (
    .clk_i, .rst_ni, .soft_rst_i,
    .swap_i  (wmode.swap),
    .ycm_i   (wmode.ycm),
    .y_lo_i  (y_lo), .y_hi_i (y_hi), .c_lo_i (c_lo), .c_hi_i (c_hi),
    .valid_i (pix_valid_i),
    .sol_i   (pix_sol_i),
    .comp_i  ({pix_c2_i, pix_c1_i, pix_c0_i}),
    .valid_o (s1_valid),
    .odd_o   (s1_odd),
    .comp_o  (s1_comp)
  );

  pof_back #(.CW(CW), .LW(LW)) i_back (
    .clk_i, .rst_ni, .soft_rst_i,
    .ycm_i   (wmode.ycm),
    .ord_i   (wmode.ord),
    .dep_i   (wmode.dep),
    .valid_i (s1_valid),
    .odd_i   (s1_odd),
    .comp_i  (s1_comp),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );

  assign out_422_en_o = wmode.f422;
  assign out_csc_en_o = wmode.fcsc;
endmodule

// File: rtl/pof_chk.sv
module pof_chk #(
  parameter int LW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            soft_rst_i,
  input logic            pix_valid_i,
  input logic            out_valid_o,
  input logic [3*LW-1:0] out_data_o,
  input logic            out_422_en_o,
  input logic            out_csc_en_o,
  input logic [2:0]      depth_w,
  input logic [2:0]      ycm_w
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && since_rst >= 2'd2) |-> $past(pix_valid_i, 2));

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_data_o == '0));

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !out_valid_o);

  a_r10_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_i |=> ($stable(out_422_en_o) && $stable(out_csc_en_o)));

  a_r9_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (depth_w == 3'd0 || depth_w > 3'd3)) |->
      (out_data_o[LW-1:8] == '0 && out_data_o[2*LW-1:LW+8] == '0 &&
       out_data_o[3*LW-1:2*LW+8] == '0));

  a_r6_lane2_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (ycm_w == 3'd1 || ycm_w == 3'd2)) |->
      (out_data_o[3*LW-1:2*LW] == '0));
endmodule

bind pix_out_fmt pof_chk #(.LW(LW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .pix_valid_i  (pix_valid_i),
  .out_valid_o  (out_valid_o),
  .out_data_o   (out_data_o),
  .out_422_en_o (out_422_en_o),
  .out_csc_en_o (out_csc_en_o),
  .depth_w      (wmode.dep),
  .ycm_w        (wmode.ycm)
);

// File: tb/test_pix_out_fmt.sv
`timescale 1ns/1ps
module test_pix_out_fmt;
  logic        clk = 1'b0, rst_n = 1'b0, srst = 1'b0;
  logic        swap = 1'b0, f422 = 1'b0, fcsc = 1'b0;
  logic [2:0]  ord = '0, ycm = '0, dep = '0;
  logic [11:0] ylo = 12'h010, yhi = 12'hFE0, clo = 12'h010, chi = 12'hFE0;
  logic        pv = 1'b0, sol = 1'b0;
  logic [11:0] c0 = '0, c1 = '0, c2 = '0;
  logic        ov, o422, ocsc;
  logic [47:0] od;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pix_out_fmt i_pix_out_fmt (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(srst),
    .cfg_rb_swap_i(swap), .cfg_order_i(ord), .cfg_ycmode_i(ycm), .cfg_depth_i(dep),
    .cfg_422_en_i(f422), .cfg_csc_en_i(fcsc),
    .cfg_y_lo_i(ylo), .cfg_y_hi_i(yhi), .cfg_c_lo_i(clo), .cfg_c_hi_i(chi),
    .pix_valid_i(pv), .pix_sol_i(sol), .pix_c0_i(c0), .pix_c1_i(c1), .pix_c2_i(c2),
    .out_valid_o(ov), .out_data_o(od), .out_422_en_o(o422), .out_csc_en_o(ocsc)
  );

  // {swap, order, mode, depth, expected}
  localparam logic [57:0] VEC [17] = '{
    {1'b0, 3'd0, 3'd0, 3'd2, 48'h0789_0456_0123},  // R4 RGB
    {1'b0, 3'd1, 3'd0, 3'd2, 48'h0123_0789_0456},  // R4 GBR
    {1'b0, 3'd2, 3'd0, 3'd2, 48'h0456_0123_0789},  // R4 BRG
    {1'b0, 3'd3, 3'd0, 3'd2, 48'h0456_0789_0123},  // R4 RBG
    {1'b0, 3'd4, 3'd0, 3'd2, 48'h0789_0123_0456},  // R4 GRB
    {1'b0, 3'd5, 3'd0, 3'd2, 48'h0123_0456_0789},  // R4 BGR
    {1'b0, 3'd6, 3'd0, 3'd2, 48'h0789_0456_0123},  // R4 fallback
    {1'b1, 3'd0, 3'd0, 3'd2, 48'h0123_0456_0789},  // R3 swap
    {1'b0, 3'd0, 3'd0, 3'd0, 48'h0078_0045_0012},  // R9 8 bit
    {1'b0, 3'd0, 3'd0, 3'd1, 48'h01E2_0115_0048},  // R9 10 bit
    {1'b0, 3'd0, 3'd0, 3'd3, 48'h7890_4560_1230},  // R9 16 bit
    {1'b0, 3'd0, 3'd0, 3'd5, 48'h0078_0045_0012},  // R9 fallback
    {1'b0, 3'd2, 3'd3, 3'd2, 48'h0789_0123_0456},  // R8 C-Y
    {1'b1, 3'd1, 3'd4, 3'd2, 48'h0123_0456_0789},  // R8 Y-C with swap
    {1'b0, 3'd0, 3'd2, 3'd2, 48'h0000_0456_0123},  // R6 Y-C-Y-C even
    {1'b0, 3'd0, 3'd1, 3'd2, 48'h0000_0123_0456},  // R6 C-Y-C-Y even
    {1'b0, 3'd1, 3'd6, 3'd2, 48'h0123_0789_0456}   // R8 mode fallback
  };

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_cfg();
    @(negedge clk); srst = 1'b1;
    @(negedge clk); @(negedge clk); srst = 1'b0;
    @(negedge clk);
  endtask

  // drive one pixel, sample two edges later
  task automatic send(logic [11:0] a, logic [11:0] b, logic [11:0] c,
                      string req, logic [47:0] exp);
    c0 = a; c1 = b; c2 = c; pv = 1'b1; sol = 1'b1;
    @(negedge clk); pv = 1'b0; sol = 1'b0;
    check({req, " latency1"}, {47'd0, ov}, 48'd0);
    @(negedge clk);
    check({req, " valid"}, {47'd0, ov}, 48'd1);
    check(req, od, exp);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20; rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", {47'd0, ov}, 48'd0);
    check("R1 reset data", od, 48'd0);
    check("R11 reset flags", {46'd0, o422, ocsc}, 48'd0);

    // R10: config written outside soft reset is ignored; R1 defaults apply
    swap = 1'b1; ord = 3'd5; ycm = 3'd4; dep = 3'd3; f422 = 1'b1; fcsc = 1'b1;
    ylo = 12'h200; yhi = 12'h300;
    @(negedge clk);
    check("R10 flags ignored", {46'd0, o422, ocsc}, 48'd0);
    send(12'h123, 12'h456, 12'h789, "R1 R10 defaults", 48'h0078_0045_0012);
    send(12'h005, 12'hFFF, 12'h800, "R5 no clamp in RGB", 48'h0080_00FF_0000);

    f422 = 1'b0; fcsc = 1'b0; ylo = 12'h010; yhi = 12'hFE0;

    for (int i = 0; i < 17; i++) begin
      {swap, ord, ycm, dep} = VEC[i][57:48];
      load_cfg();
      send(12'h123, 12'h456, 12'h789, $sformatf("vector %0d", i), VEC[i][47:0]);
    end

    // R5 default limits
    swap = 1'b0; ord = 3'd0; ycm = 3'd4; dep = 3'd2;
    load_cfg();
    send(12'h005, 12'hFFF, 12'h800, "R5 default limits", 48'h0800_0FE0_0010);
    // R5 custom limits
    ylo = 12'h100; yhi = 12'h200; clo = 12'h300; chi = 12'h400;
    load_cfg();
    send(12'h050, 12'h350, 12'h500, "R5 custom limits", 48'h0400_0350_0100);
    send(12'h250, 12'h200, 12'h350, "R5 custom limits hi", 48'h0350_0300_0200);
    ylo = 12'h010; yhi = 12'hFE0; clo = 12'h010; chi = 12'hFE0;

    // R6 / R7 alternation with restart at line start
    ycm = 3'd2;
    load_cfg();
    c0 = 12'h123; c1 = 12'h456; c2 = 12'h789;
    for (int k = 0; k < 6; k++) begin
      if (k >= 2) begin
        case (k)
          2: check("R6 even Cb", od, 48'h0000_0456_0123);
          3: check("R6 odd Cr", od, 48'h0000_0789_0123);
          4: check("R6 even again", od, 48'h0000_0456_0123);
          default: check("R7 restart at line start", od, 48'h0000_0456_0123);
        endcase
      end
      pv = (k < 4);
      sol = (k == 0) || (k == 3);
      @(negedge clk);
    end
    pv = 1'b0; sol = 1'b0;
    @(negedge clk);

    // R6 C-Y-C-Y odd pixel
    ycm = 3'd1;
    load_cfg();
    pv = 1'b1; sol = 1'b1;
    @(negedge clk); sol = 1'b0;
    @(negedge clk); pv = 1'b0;
    check("R6 C-Y-C-Y even", od, 48'h0000_0123_0456);
    @(negedge clk);
    check("R6 C-Y-C-Y odd", od, 48'h0000_0123_0789);

    // R11 flags
    f422 = 1'b1; fcsc = 1'b0; load_cfg();
    check("R11 flags 422", {46'd0, o422, ocsc}, 48'd2);
    f422 = 1'b0; fcsc = 1'b1; load_cfg();
    check("R11 flags csc", {46'd0, o422, ocsc}, 48'd1);

    // R10 pixels during soft reset dropped
    @(negedge clk); srst = 1'b1; pv = 1'b1;
    @(negedge clk); pv = 1'b0;
    @(negedge clk);
    check("R10 dropped in soft reset", {47'd0, ov}, 48'd0);
    srst = 1'b0;
    @(negedge clk);
    check("R2 idle after soft reset", {47'd0, ov}, 48'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule